// File: doc/BRIEF.md
# Eight-channel timer register front end

This block is the software-facing side of a bank of eight down-counting timer channels. It sits on a simple valid/ready word bus and decodes each request. A request to a channel's count, reload or match words becomes a one-cycle write strobe, or a read-select, towards the external counters. The block also holds a packed control register with four bits per channel: run, external time base, overflow interrupt enable and pulse output. These bits drive the counters directly.

A change to the control register is not applied in a single step. A small sequencer moves the register through three one-cycle phases. Channels that are being stopped stop first. The configuration bits change next. Channels that are being started start last. So no counter ever runs with a mix of old and new settings. The block also keeps a sticky per-channel interrupt status word with write-one-to-clear bits. It offers a second way to clear control bits, which is accepted only after a key value has unlocked it.

The sequencer has four states. `ST_IDLE` accepts requests. A control write, or an unlocked clear write, moves it to `ST_DROP`. `ST_DROP` clears the run bits that fall and moves to `ST_CONFIG`. `ST_CONFIG` loads the configuration bits and moves to `ST_RAISE`. `ST_RAISE` loads the final value and returns to `ST_IDLE`. `req_ready` is low in every state except `ST_IDLE`.

Top module: `tmr_regfront`

## Requirements
- R1: Address bits [1:0] are ignored. Offsets 0x00–0x2F map to channels 0–2 (channel = addr[7:4]), and offsets 0x40–0x8F map to channels 3–7 (channel = addr[7:4]−1). Within a channel, addr[3:2] selects the word. A write produces a one-cycle `ch_wr_strobe` in the cycle after acceptance, carrying the channel, word and data. A read presents the channel and word combinationally on `ch_rd_idx`/`ch_rd_word`, and the next cycle returns `ch_rd_data` as sampled at acceptance.
- R2: The control register at 0x30 holds bits [4i+3:4i] for channel i: bit 4i is run, 4i+1 is external time base, 4i+2 is overflow interrupt enable and 4i+3 is pulse. The bits drive `ch_enable`, `ch_extclk`, `ch_ovf_ie` and `ch_pulse`, and a read of 0x30 returns the register.
- R3: On a control update, a channel whose run bit falls shows run low one cycle before any of its configuration bits change.
- R4: On a control update, a channel whose run bit rises shows its new configuration one cycle before run goes high.
- R5: Pulse bits of channels below `PULSE_FIRST` (default 4) are never stored. A control write that sets one raises `pulse_misuse` for one cycle, in the cycle after acceptance.
- R6: An event pulse on `ch_event[i]` sets status bit i at the next edge. A write to 0x34 clears each status bit whose data bit is 1, and an event in the same cycle wins. The status is read at 0x34 and shown on `irq_pending`.
- R7: A write to 0x38 with data[8:1]=0xAE unlocks clearing, and data[8:1]=0xEA locks it again. Any other value leaves the state unchanged. A read of 0x38 returns 1 in bit 0 when unlocked.
- R8: While unlocked, a write to 0x3C clears every control bit whose data bit is 1, using the same three-phase order as R3/R4. While locked, the write has no effect and `req_ready` stays high.
- R9: After reset the control register, the status word and the unlock state are all zero, and every channel output is low.
- R10: A read of an unmapped offset (0x90–0xFF, or any address with bits [31:8] nonzero) returns zero and raises `rsp_err` for one cycle. An unmapped write changes nothing. Offset 0x3C reads as zero without error.
- R11: Every accepted read gives `rsp_valid` in the next cycle. A control update holds `req_ready` low for exactly three cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Read hit an unmapped offset |
| ch_wr_strobe | output | 1 | Channel register write pulse |
| ch_wr_idx | output | 3 | Channel of the write |
| ch_wr_word | output | 2 | Word of the write (0 count, 1 reload, 2/3 match) |
| ch_wr_data | output | 32 | Data of the write |
| ch_rd_idx | output | 3 | Channel selected by the current read |
| ch_rd_word | output | 2 | Word selected by the current read |
| ch_rd_data | input | 32 | Selected channel word from the counters |
| ch_enable | output | 8 | Per-channel run |
| ch_extclk | output | 8 | Per-channel external time base select |
| ch_ovf_ie | output | 8 | Per-channel overflow interrupt enable |
| ch_pulse | output | 8 | Per-channel pulse output enable |
| pulse_misuse | output | 1 | Pulse requested on a channel that lacks it |
| ch_event | input | 8 | Per-channel event pulses |
| irq_pending | output | 8 | Sticky interrupt status |

## Verification
The hardest situations to reach are the two intermediate phases of a control update. In these phases a channel is stopped but still has its old configuration, or has its new configuration but is not yet running. They last one cycle each and are visible only while the bus is stalled. The bench keeps a behavioural copy of the expected outputs. It moves this copy through the phases at the right clock edges and compares it on every clock. It issues writes that stop, reconfigure and start channels together, including one made through the unlocked clear path. The other hard case is an event and a clear of the same status bit in the same cycle, which the bench sets up by raising the event in the cycle the clear write is accepted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH   = 8;
    localparam int CBITS = 4;
    localparam int CW    = NCH * CBITS;

    typedef enum logic [2:0] {
        K_NONE, K_CHAN, K_CTRL, K_STAT, K_LOCK, K_CLR
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE, ST_DROP, ST_CONFIG, ST_RAISE
    } seq_t;

    function automatic logic [CW-1:0] field_mask(int bitpos);
        logic [CW-1:0] m;
        m = '0;
        for (int i = 0; i < NCH; i++) m[i*CBITS+bitpos] = 1'b1;
        return m;
    endfunction

    function automatic logic [CW-1:0] low_pulse_mask(int first);
        logic [CW-1:0] m;
        m = '0;
        for (int i = 0; i < NCH; i++)
            if (i < first) m[i*CBITS+3] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
(
    input  logic [31:0] addr,
    output kind_t       kind,
    output logic [2:0]  ch_idx,
    output logic [1:0]  word
);
    logic [3:0] page;
    assign page = addr[7:4];
    assign word = addr[3:2];

    always_comb begin
        kind   = K_NONE;
        ch_idx = '0;
        if (addr[31:8] == '0) begin
            if (page <= 4'd2) begin
                kind   = K_CHAN;
                ch_idx = page[2:0];
            end else if (page == 4'd3) begin
                unique case (addr[3:2])
                    2'd0: kind = K_CTRL;
                    2'd1: kind = K_STAT;
                    2'd2: kind = K_LOCK;
                    2'd3: kind = K_CLR;
                endcase
            end else if (page <= 4'd8) begin
                kind   = K_CHAN;
                ch_idx = 3'(page - 4'd1);
            end
        end
    end
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] target,
    output logic [CW-1:0] ctrl_q,
    output logic          busy
);
    localparam logic [CW-1:0] EN_MASK = field_mask(0);

    seq_t          state_q, state_d;
    logic [CW-1:0] target_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DROP;
            ST_DROP:   state_d = ST_CONFIG;
            ST_CONFIG: state_d = ST_RAISE;
            ST_RAISE:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            target_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start) target_q <= target;
                ST_DROP:   ctrl_q <= ctrl_q & (target_q | ~EN_MASK);
                ST_CONFIG: ctrl_q <= (ctrl_q & EN_MASK) | (target_q & ~EN_MASK);
                ST_RAISE:  ctrl_q <= target_q;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_in,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~(clr_we ? clr_mask : '0)) | event_in;
    end
endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
    import tmr_pkg::*;
#(
    parameter int         PULSE_FIRST = 4,
    parameter logic [7:0] UNLOCK_KEY  = 8'hAE,
    parameter logic [7:0] LOCK_KEY    = 8'hEA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        ch_wr_strobe,
    output logic [2:0]  ch_wr_idx,
    output logic [1:0]  ch_wr_word,
    output logic [31:0] ch_wr_data,
    output logic [2:0]  ch_rd_idx,
    output logic [1:0]  ch_rd_word,
    input  logic [31:0] ch_rd_data,
    output logic [7:0]  ch_enable,
    output logic [7:0]  ch_extclk,
    output logic [7:0]  ch_ovf_ie,
    output logic [7:0]  ch_pulse,
    output logic        pulse_misuse,
    input  logic [7:0]  ch_event,
    output logic [7:0]  irq_pending
);
    localparam logic [CW-1:0] NOPULSE = low_pulse_mask(PULSE_FIRST);

    kind_t         kind;
    logic [2:0]    dec_idx;
    logic [1:0]    dec_word;
    logic          busy, accept, wr, rd, start, unlock_q;
    logic [CW-1:0] ctrl_q, target;

    tmr_addr_dec u_dec (
        .addr(req_addr), .kind(kind), .ch_idx(dec_idx), .word(dec_word)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign wr        = accept && req_write;
    assign rd        = accept && !req_write;
    assign start     = wr && ((kind == K_CTRL) || (kind == K_CLR && unlock_q));
    assign target    = (kind == K_CTRL) ? (req_wdata & ~NOPULSE)
                                        : (ctrl_q & ~req_wdata);

    tmr_ctrl_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .target(target),
        .ctrl_q(ctrl_q), .busy(busy)
    );

    tmr_irq_stat #(.N(NCH)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_in(ch_event),
        .clr_we(wr && kind == K_STAT), .clr_mask(req_wdata[NCH-1:0]),
        .status(irq_pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unlock_q <= 1'b0;
        else if (wr && kind == K_LOCK) begin
            if (req_wdata[8:1] == UNLOCK_KEY)    unlock_q <= 1'b1;
            else if (req_wdata[8:1] == LOCK_KEY) unlock_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_wr_strobe <= 1'b0;
            ch_wr_idx    <= '0;
            ch_wr_word   <= '0;
            ch_wr_data   <= '0;
            pulse_misuse <= 1'b0;
        end else begin
            ch_wr_strobe <= wr && kind == K_CHAN;
            pulse_misuse <= wr && kind == K_CTRL && |(req_wdata & NOPULSE);
            if (wr && kind == K_CHAN) begin
                ch_wr_idx  <= dec_idx;
                ch_wr_word <= dec_word;
                ch_wr_data <= req_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= rd;
            rsp_err   <= rd && kind == K_NONE;
            if (rd) begin
                unique case (kind)
                    K_CHAN:  rsp_rdata <= ch_rd_data;
                    K_CTRL:  rsp_rdata <= ctrl_q;
                    K_STAT:  rsp_rdata <= 32'(irq_pending);
                    K_LOCK:  rsp_rdata <= {31'b0, unlock_q};
                    default: rsp_rdata <= '0;
                endcase
            end
        end
    end

    assign ch_rd_idx  = dec_idx;
    assign ch_rd_word = dec_word;

    for (genvar i = 0; i < NCH; i++) begin : g_unpack
        assign ch_enable[i] = ctrl_q[i*CBITS+0];
        assign ch_extclk[i] = ctrl_q[i*CBITS+1];
        assign ch_ovf_ie[i] = ctrl_q[i*CBITS+2];
        assign ch_pulse[i]  = ctrl_q[i*CBITS+3];
    end
endmodule

// File: rtl/tmr_regfront_chk.sv
module tmr_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic [7:0]  ch_enable,
    input logic [7:0]  ch_extclk,
    input logic [7:0]  ch_ovf_ie,
    input logic [7:0]  ch_pulse,
    input logic [7:0]  ch_event,
    input logic [7:0]  irq_pending,
    input logic        unlocked
);
    a_r3_stop_before_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ch_enable) & ~ch_enable)) |->
            ($stable(ch_extclk) && $stable(ch_ovf_ie) && $stable(ch_pulse)));

    a_r4_cfg_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(ch_enable) & ch_enable)) |->
            ($stable(ch_extclk) && $stable(ch_ovf_ie) && $stable(ch_pulse)));

    a_r11_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    a_r10_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

    a_r6_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_event) |=> ((irq_pending & $past(ch_event)) == $past(ch_event)));

    a_r8_locked_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_addr == 32'h3C && !unlocked)
            |=> req_ready);
endmodule

bind tmr_regfront tmr_regfront_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ch_enable(ch_enable),
    .ch_extclk(ch_extclk), .ch_ovf_ie(ch_ovf_ie), .ch_pulse(ch_pulse),
    .ch_event(ch_event), .irq_pending(irq_pending), .unlocked(unlock_q)
);

// File: tb/sim_tmr_regfront.sv
`timescale 1ns/1ps
module sim_tmr_regfront;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, ch_wr_strobe, pulse_misuse;
    logic [31:0] rsp_rdata, ch_wr_data, ch_rd_data;
    logic [2:0]  ch_wr_idx, ch_rd_idx;
    logic [1:0]  ch_wr_word, ch_rd_word;
    logic [7:0]  ch_enable, ch_extclk, ch_ovf_ie, ch_pulse, irq_pending;
    logic [7:0]  ch_event = '0;

    int checks = 0, errors = 0;
    logic [31:0] m_ctrl = '0;
    bit cmp_on = 1'b0;
    logic [31:0] rd_v;
    logic rd_e;

    always #4 clk = ~clk;

    assign ch_rd_data = {16'hC0DE, 8'(ch_rd_idx), 8'(ch_rd_word)};

    tmr_regfront u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fld(input logic [31:0] v, input int b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[4*i+b];
        return r;
    endfunction

    // Per-clock comparison against the behavioural model (R2, R3, R4)
    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            chk(ch_enable == fld(m_ctrl,0), "R3 run bits", 32'(ch_enable), 32'(fld(m_ctrl,0)));
            chk({ch_extclk,ch_ovf_ie,ch_pulse} == {fld(m_ctrl,1),fld(m_ctrl,2),fld(m_ctrl,3)},
                "R4 config bits", {8'h0,ch_extclk,ch_ovf_ie,ch_pulse},
                {8'h0,fld(m_ctrl,1),fld(m_ctrl,2),fld(m_ctrl,3)});
        end
    end

    task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [31:0] a, output logic [31:0] v, output logic e);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R11 rsp_valid", 32'(rsp_valid), 1);
        v = rsp_rdata; e = rsp_err;
    endtask

    // Ordered update: model steps through drop, config, raise
    task automatic ctrl_apply(input logic [31:0] a, input logic [31:0] d,
                              input logic [31:0] tgt);
        bus_wr(a, d);
        chk(req_ready == 1'b0, "R11 stall", 32'(req_ready), 0);
        @(negedge clk); m_ctrl = m_ctrl & (tgt | 32'hEEEE_EEEE);
        @(negedge clk); m_ctrl = (m_ctrl & 32'h1111_1111) | (tgt & 32'hEEEE_EEEE);
        @(negedge clk); m_ctrl = tgt;
        chk(req_ready == 1'b1, "R11 ready after three", 32'(req_ready), 1);
    endtask

    initial begin
        #(8*50000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        // R9 reset state
        chk({ch_enable,ch_extclk,ch_ovf_ie,ch_pulse} == 0, "R9 outputs", {ch_enable,ch_extclk,ch_ovf_ie,ch_pulse}, 0);
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 0, "R9 control", rd_v, 0);
        bus_rd(32'h34, rd_v, rd_e); chk(rd_v == 0, "R9 status", rd_v, 0);
        bus_rd(32'h38, rd_v, rd_e); chk(rd_v == 0, "R9 lock", rd_v, 0);

        // R4: start channel 0 with external time base
        ctrl_apply(32'h30, 32'h0000_0003, 32'h0000_0003);
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 32'h3, "R2 readback", rd_v, 32'h3);
        // R3: stop channel 0, change config; start channel 5
        ctrl_apply(32'h30, 32'h0070_0004, 32'h0070_0004);
        // R5: pulse on ch3 dropped and flagged, ch7 kept
        bus_wr(32'h30, 32'h8000_8001);
        chk(pulse_misuse == 1'b1, "R5 misuse", 32'(pulse_misuse), 1);
        @(negedge clk); m_ctrl = m_ctrl & (32'h8000_0001 | 32'hEEEE_EEEE);
        @(negedge clk); m_ctrl = (m_ctrl & 32'h1111_1111) | (32'h8000_0001 & 32'hEEEE_EEEE);
        @(negedge clk); m_ctrl = 32'h8000_0001;
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 32'h8000_0001, "R5 stored", rd_v, 32'h8000_0001);
        chk(ch_pulse == 8'h80, "R5 pulse out", 32'(ch_pulse), 32'h80);
        bus_wr(32'h30, 32'h8000_0001);
        chk(pulse_misuse == 1'b0, "R5 no misuse", 32'(pulse_misuse), 0);
        repeat (3) @(negedge clk);

        // R1 channel access
        bus_wr(32'h48, 32'h0000_1234);
        chk(ch_wr_strobe && ch_wr_idx == 3 && ch_wr_word == 2 && ch_wr_data == 32'h1234,
            "R1 write 0x48", {ch_wr_strobe, 24'h0, ch_wr_idx, ch_wr_word}, {1'b1, 24'h0, 3'd3, 2'd2});
        @(negedge clk); chk(ch_wr_strobe == 0, "R1 strobe one cycle", 32'(ch_wr_strobe), 0);
        bus_wr(32'h04, 32'hABCD);
        chk(ch_wr_strobe && ch_wr_idx == 0 && ch_wr_word == 1, "R1 write 0x04", {ch_wr_idx, ch_wr_word}, {3'd0, 2'd1});
        bus_rd(32'h28, rd_v, rd_e); chk(rd_v == 32'hC0DE_0202, "R1 read 0x28", rd_v, 32'hC0DE_0202);
        bus_rd(32'h8C, rd_v, rd_e); chk(rd_v == 32'hC0DE_0703, "R1 read 0x8C", rd_v, 32'hC0DE_0703);

        // R6 status
        ch_event = 8'h05; @(negedge clk); ch_event = 8'h00;
        chk(irq_pending == 8'h05, "R6 set", 32'(irq_pending), 5);
        bus_wr(32'h34, 32'h1);
        chk(irq_pending == 8'h04, "R6 clear", 32'(irq_pending), 4);
        ch_event = 8'h04; bus_wr(32'h34, 32'h4); ch_event = 8'h00;
        chk(irq_pending == 8'h04, "R6 event wins", 32'(irq_pending), 4);
        bus_rd(32'h34, rd_v, rd_e); chk(rd_v == 32'h4, "R6 read", rd_v, 4);

        // R8 locked clear ignored
        bus_wr(32'h3C, 32'hFFFF_FFFF);
        chk(req_ready == 1'b1, "R8 locked no stall", 32'(req_ready), 1);
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 32'h8000_0001, "R8 locked", rd_v, 32'h8000_0001);
        // R7 unlock
        bus_wr(32'h38, 32'h0000_015C);
        bus_rd(32'h38, rd_v, rd_e); chk(rd_v == 1, "R7 unlocked", rd_v, 1);
        // R8 ordered clear: stop ch0, then drop ch7 pulse
        ctrl_apply(32'h3C, 32'h8000_0001, 32'h0000_0000);
        ctrl_apply(32'h30, 32'h0000_0027, 32'h0000_0027);
        ctrl_apply(32'h3C, 32'h0000_0005, 32'h0000_0022);
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 32'h22, "R8 cleared", rd_v, 32'h22);
        bus_wr(32'h38, 32'h0000_0002);
        bus_rd(32'h38, rd_v, rd_e); chk(rd_v == 1, "R7 other key", rd_v, 1);
        bus_wr(32'h38, 32'h0000_01D4);
        bus_rd(32'h38, rd_v, rd_e); chk(rd_v == 0, "R7 locked", rd_v, 0);

        // R10 unmapped
        bus_rd(32'h90, rd_v, rd_e); chk(rd_e && rd_v == 0, "R10 0x90", {rd_e, rd_v[30:0]}, 32'h8000_0000);
        chk(rsp_err == 1'b1, "R10 err pulse", 32'(rsp_err), 1);
        @(negedge clk); chk(rsp_err == 1'b0, "R10 err one cycle", 32'(rsp_err), 0);
        bus_rd(32'h1000_0030, rd_v, rd_e); chk(rd_e == 1, "R10 high bits", 32'(rd_e), 1);
        bus_rd(32'h3C, rd_v, rd_e); chk(!rd_e && rd_v == 0, "R10 0x3C", {rd_e, rd_v[30:0]}, 0);
        bus_wr(32'h90, 32'hFFFF_FFFF);
        bus_wr(32'h1000_0030, 32'hFFFF_FFFF);
        bus_rd(32'h30, rd_v, rd_e); chk(rd_v == 32'h22, "R10 write ignored", rd_v, 32'h22);
        bus_rd(32'h34, rd_v, rd_e); chk(rd_v == 32'h4, "R10 status kept", rd_v, 4);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule